// File: doc/BRIEF.md
# Task-Switch Segment-Load Sequencer

This block runs the state-loading phase of a hardware task switch. A new task-state descriptor has already been fetched. The caller hands the block a one-shot record holding:
- the selector of the new task-state segment, with its type and present flags;
- an optional stack-fetch window for a privilege-changing call;
- the six segment selectors of the new task.

On `start`, the block first screens the new task state. Any fault found here is reported in the old task's context and nothing changes. If the screen passes, the switch commits. The task register takes the new selector, and for a nested switch (call or interrupt) the back-link takes the old task register value.

After the commit, the block copies all six selectors into the segment registers in one step. Only then does it validate them, one at a time, in the order code, stack, data0..data3. For each non-null selector it asks a descriptor port for the selector's type and present attributes. The first register that fails ends the checking. Registers after the failing one stay loaded but are never examined.

The outcome is a single `done` pulse. When a fault occurred, `fault_valid` pulses with it and carries:
- the exception vector;
- a 16-bit error code built from the offending selector;
- a context bit: 0 means the saved code pointer is the instruction that started the switch, 1 means it is the first instruction of the new task.

Top module: `task_switch_loader`

## Requirements
- R1: `start` is accepted only while `busy` is low; `busy` then stays high until the cycle that `done` pulses for exactly one clock. A `start` while busy is ignored.
- R2: Before commit, a new task state with a bad type raises vector 10; one that is marked not present (type good) raises vector 11. Both report context 0 and leave the task register, back-link and all segment registers unchanged.
- R3: When the stack fetch is enabled and offset+7 exceeds the task-state limit, the switch faults before commit with vector 10, context 0 and the task-state selector in the error code. An offset of exactly limit-7 passes. The type and present checks take priority.
- R4: At commit the task register takes the new task-state selector. The back-link takes the previous task register value only when `from_call` is set; otherwise it keeps its value.
- R5: All six segment registers are written together in the cycle after commit. This happens before any descriptor request, and also when a later check faults.
- R6: Checks run in the order code, stack, data0, data1, data2, data3 (bits [15:0] through [95:80] of the selector vectors). Each non-null selector issues one request. `desc_req` and `desc_sel` hold until `desc_rsp_valid`.
- R7: A null code selector (bits [15:2] zero) faults with vector 10 without a request. For a fetched code descriptor, a bad type faults with vector 10, and a good type that is not present faults with vector 11.
- R8: A null stack selector, or a stack descriptor with a bad type, faults with vector 10. A stack descriptor that is not present (type good) faults with vector 12. Stack faults always report context 1.
- R9: A null data selector is accepted without a request. A data descriptor with a bad type faults with vector 10, and one that is not present faults with vector 11.
- R10: Every fault found after commit reports context 1. No request is issued after the first failing register, and `done` follows in the same cycle as the fault.
- R11: The error code is the offending selector with bits [15:2] kept, bit 1 zero, and bit 0 equal to `ext_evt`. The offending selector is the task-state selector before commit and the failing segment selector after.
- R12: An active-low asynchronous reset returns the block to idle. It clears the task register, back-link, segment registers and all fault outputs, and abandons any switch in progress without a `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a switch using the record inputs |
| from_call | input | 1 | Switch is nested (call or interrupt); update back-link |
| ext_evt | input | 1 | Switch was triggered by an external event; copied into error code bit 0 |
| tss_sel | input | 16 | Selector of the new task-state segment |
| tss_type_ok | input | 1 | New task-state descriptor has a valid type |
| tss_present | input | 1 | New task-state descriptor is present |
| stk_fetch | input | 1 | Privilege-changing call needs a stack pointer fetch |
| stk_ofs | input | 16 | Byte offset of the stack pointer pair |
| tss_limit | input | 16 | Limit of the task-state segment |
| seg_sel_in | input | 96 | New selectors: code [15:0], stack [31:16], data0..data3 above |
| busy | output | 1 | A switch is in progress |
| done | output | 1 | One-cycle completion pulse |
| desc_req | output | 1 | Descriptor attribute request pending |
| desc_sel | output | 16 | Selector whose descriptor is requested |
| desc_rsp_valid | input | 1 | Attribute response for the pending request |
| desc_type_ok | input | 1 | Descriptor type is acceptable for the register |
| desc_present | input | 1 | Descriptor present flag |
| tr_q | output | 16 | Task register |
| link_q | output | 16 | Back-link to the previous task |
| seg_q | output | 96 | Segment registers, same layout as `seg_sel_in` |
| fault_valid | output | 1 | Fault reported with this `done` |
| fault_vec | output | 8 | Exception vector |
| fault_err | output | 16 | Error code |
| fault_ctx | output | 1 | 0 = old-task context, 1 = new-task context |

## Verification
The assertions assume that `desc_rsp_valid` rises only while `desc_req` is high, and that the attribute flags matter only in that cycle. They also assume each switch names a task-state selector different from the one currently in the task register. The testbench respects both:
- its descriptor responder is gated by `desc_req` itself, and its optional stall only delays the response;
- every vector in the table, and every directed case, uses a fresh task-state selector.

Descriptor attributes are coded into the selectors the bench chooses: bit 14 set means a bad type, and bit 13 set means not present.

// File: rtl/task_switch_loader.sv
module task_switch_loader #(
  parameter int SEL_W = 16,
  parameter int VEC_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  from_call,
  input  logic                  ext_evt,
  input  logic [SEL_W-1:0]      tss_sel,
  input  logic                  tss_type_ok,
  input  logic                  tss_present,
  input  logic                  stk_fetch,
  input  logic [SEL_W-1:0]      stk_ofs,
  input  logic [SEL_W-1:0]      tss_limit,
  input  logic [6*SEL_W-1:0]    seg_sel_in,
  output logic                  busy,
  output logic                  done,
  output logic                  desc_req,
  output logic [SEL_W-1:0]      desc_sel,
  input  logic                  desc_rsp_valid,
  input  logic                  desc_type_ok,
  input  logic                  desc_present,
  output logic [SEL_W-1:0]      tr_q,
  output logic [SEL_W-1:0]      link_q,
  output logic [6*SEL_W-1:0]    seg_q,
  output logic                  fault_valid,
  output logic [VEC_W-1:0]      fault_vec,
  output logic [SEL_W-1:0]      fault_err,
  output logic                  fault_ctx
);
  localparam int NSEG = 6;
  localparam int SW = 6 * SEL_W;
  localparam logic [2:0] LAST_IDX = 3'(NSEG - 1);
  localparam logic [VEC_W-1:0] V_BAD_TSS = VEC_W'(10);
  localparam logic [VEC_W-1:0] V_ABSENT = VEC_W'(11);
  localparam logic [VEC_W-1:0] V_STACK = VEC_W'(12);

  typedef enum logic [2:0] {S_IDLE, S_VERIFY, S_COMMIT, S_LOAD, S_CHECK} st_t;
  st_t st;

  logic [SEL_W-1:0] r_tss, r_ofs, r_lim;
  logic             r_call, r_ext, r_type_ok, r_present, r_stk;
  logic [SW-1:0]    r_seg;
  logic [2:0]       idx;
  logic [SEL_W-1:0] cur_sel;

  always_comb begin
    case (idx)
      3'd0:    cur_sel = seg_q[0*SEL_W +: SEL_W];
      3'd1:    cur_sel = seg_q[1*SEL_W +: SEL_W];
      3'd2:    cur_sel = seg_q[2*SEL_W +: SEL_W];
      3'd3:    cur_sel = seg_q[3*SEL_W +: SEL_W];
      3'd4:    cur_sel = seg_q[4*SEL_W +: SEL_W];
      default: cur_sel = seg_q[5*SEL_W +: SEL_W];
    endcase
  end

  wire is_null  = (cur_sel[SEL_W-1:2] == '0);
  wire is_stack = (idx == 3'd1);
  wire is_data  = (idx >= 3'd2);
  wire stk_viol = r_stk && (({1'b0, r_ofs} + (SEL_W+1)'(7)) > {1'b0, r_lim});

  assign busy     = (st != S_IDLE);
  assign desc_req = (st == S_CHECK) && !is_null;
  assign desc_sel = cur_sel;

  wire step = (st == S_CHECK) && (is_null || desc_rsp_valid);

  logic             chk_fault;
  logic [VEC_W-1:0] chk_vec;
  always_comb begin
    chk_fault = 1'b0;
    chk_vec   = V_BAD_TSS;
    if (is_null) begin
      chk_fault = !is_data;
    end else if (!desc_type_ok) begin
      chk_fault = 1'b1;
    end else if (!desc_present) begin
      chk_fault = 1'b1;
      chk_vec   = is_stack ? V_STACK : V_ABSENT;
    end
  end

  function automatic logic [SEL_W-1:0] err_code(input logic [SEL_W-1:0] s, input logic e);
    return {s[SEL_W-1:2], 1'b0, e};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      r_tss       <= '0;
      r_ofs       <= '0;
      r_lim       <= '0;
      r_call      <= 1'b0;
      r_ext       <= 1'b0;
      r_type_ok   <= 1'b0;
      r_present   <= 1'b0;
      r_stk       <= 1'b0;
      r_seg       <= '0;
      idx         <= '0;
      tr_q        <= '0;
      link_q      <= '0;
      seg_q       <= '0;
      done        <= 1'b0;
      fault_valid <= 1'b0;
      fault_vec   <= '0;
      fault_err   <= '0;
      fault_ctx   <= 1'b0;
    end else begin
      done        <= 1'b0;
      fault_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          r_tss     <= tss_sel;
          r_ofs     <= stk_ofs;
          r_lim     <= tss_limit;
          r_call    <= from_call;
          r_ext     <= ext_evt;
          r_type_ok <= tss_type_ok;
          r_present <= tss_present;
          r_stk     <= stk_fetch;
          r_seg     <= seg_sel_in;
          st        <= S_VERIFY;
        end
        S_VERIFY: begin
          if (!r_type_ok || !r_present || stk_viol) begin
            done        <= 1'b1;
            fault_valid <= 1'b1;
            fault_vec   <= (r_type_ok && !r_present) ? V_ABSENT : V_BAD_TSS;
            fault_err   <= err_code(r_tss, r_ext);
            fault_ctx   <= 1'b0;
            st          <= S_IDLE;
          end else begin
            st <= S_COMMIT;
          end
        end
        S_COMMIT: begin
          tr_q <= r_tss;
          if (r_call) link_q <= tr_q;
          st <= S_LOAD;
        end
        S_LOAD: begin
          seg_q <= r_seg;
          idx   <= '0;
          st    <= S_CHECK;
        end
        S_CHECK: if (step) begin
          if (chk_fault) begin
            done        <= 1'b1;
            fault_valid <= 1'b1;
            fault_vec   <= chk_vec;
            fault_err   <= err_code(cur_sel, r_ext);
            fault_ctx   <= 1'b1;
            st          <= S_IDLE;
          end else if (idx == LAST_IDX) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            idx <= idx + 3'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> done && !busy); // R10
  AST_PRECOMMIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !fault_ctx |-> $stable(tr_q) && $stable(link_q) && $stable(seg_q)); // R2
  AST_STACK_NEW_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && fault_vec == V_STACK |-> fault_ctx); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req && !desc_rsp_valid |=> desc_req && $stable(desc_sel)); // R6
  AST_NO_REQ_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !desc_req); // R10
endmodule

// File: tb/task_switch_loader_tb_top.sv
`timescale 1ns/1ps
module task_switch_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 0, from_call = 0, ext_evt = 0, tss_type_ok = 0, tss_present = 0, stk_fetch = 0;
  logic [15:0] tss_sel = 0, stk_ofs = 0, tss_limit = 0;
  logic [95:0] seg_sel_in = 0;
  logic        busy, done, desc_req, desc_rsp_valid, desc_type_ok, desc_present;
  logic [15:0] desc_sel, tr_q, link_q, fault_err;
  logic [95:0] seg_q;
  logic        fault_valid, fault_ctx;
  logic [7:0]  fault_vec;

  logic        lat = 0;
  logic [31:0] cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  assign desc_rsp_valid = desc_req && (!lat || cyc[0]);
  assign desc_type_ok   = !desc_sel[14];
  assign desc_present   = !desc_sel[13];

  task_switch_loader dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .from_call(from_call), .ext_evt(ext_evt),
    .tss_sel(tss_sel), .tss_type_ok(tss_type_ok), .tss_present(tss_present),
    .stk_fetch(stk_fetch), .stk_ofs(stk_ofs), .tss_limit(tss_limit), .seg_sel_in(seg_sel_in),
    .busy(busy), .done(done), .desc_req(desc_req), .desc_sel(desc_sel),
    .desc_rsp_valid(desc_rsp_valid), .desc_type_ok(desc_type_ok), .desc_present(desc_present),
    .tr_q(tr_q), .link_q(link_q), .seg_q(seg_q), .fault_valid(fault_valid),
    .fault_vec(fault_vec), .fault_err(fault_err), .fault_ctx(fault_ctx));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [15:0] tss; logic tok; logic pres; logic stk; logic [15:0] ofs; logic [15:0] lim;
    logic call; logic ext; logic [95:0] segs;
    logic e_flt; logic [7:0] e_vec; logic [15:0] e_err; logic e_ctx; logic [3:0] e_nreq;
  } vec_t;

  localparam logic [95:0] SA = {16'h0000, 16'h0000, 16'h0018, 16'h0018, 16'h0010, 16'h0008};
  localparam logic [95:0] SB = {16'h0024, 16'h0020, 16'h0018, 16'h001B, 16'h0010, 16'h0008};
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{16'h0028,1,1,0,16'h0,16'h0,0,0,SA, 0,8'd0,16'h0000,0,4'd4},   // R4 R9 plain switch, null data skipped
    '{16'h0030,1,1,0,16'h0,16'h0,1,0,SB, 0,8'd0,16'h0000,0,4'd6},   // R4 R6 nested, all six fetched
    '{16'h0038,0,1,0,16'h0,16'h0,1,1,SA, 1,8'd10,16'h0039,0,4'd0},  // R2 R11 bad type, ext set
    '{16'h0040,1,0,0,16'h0,16'h0,0,0,SA, 1,8'd11,16'h0040,0,4'd0},  // R2 not present
    '{16'h0048,0,0,0,16'h0,16'h0,0,0,SA, 1,8'd10,16'h0048,0,4'd0},  // R2 type before present
    '{16'h0050,1,1,1,16'h4,16'hA,0,0,SA, 1,8'd10,16'h0050,0,4'd0},  // R3 limit one short
    '{16'h0050,1,1,1,16'h4,16'hB,0,0,SA, 0,8'd0,16'h0000,0,4'd4},   // R3 exact fit
    '{16'h0058,1,1,0,16'h0,16'h0,1,0,{16'h0,16'h0,16'h18,16'h18,16'h10,16'h4008}, 1,8'd10,16'h4008,1,4'd1}, // R7
    '{16'h0060,1,1,0,16'h0,16'h0,0,0,{16'h0,16'h0,16'h18,16'h18,16'h10,16'h2008}, 1,8'd11,16'h2008,1,4'd1}, // R7
    '{16'h0068,1,1,0,16'h0,16'h0,0,0,{16'h0,16'h0,16'h18,16'h18,16'h2010,16'h8}, 1,8'd12,16'h2010,1,4'd2}, // R8
    '{16'h0070,1,1,0,16'h0,16'h0,0,0,{16'h0,16'h0,16'h18,16'h18,16'h4010,16'h8}, 1,8'd10,16'h4010,1,4'd2}, // R8
    '{16'h0078,1,1,0,16'h0,16'h0,0,1,{16'h0,16'h0,16'h18,16'h18,16'h0003,16'h8}, 1,8'd10,16'h0001,1,4'd1}, // R8 R11
    '{16'h0080,1,1,0,16'h0,16'h0,0,0,{16'h0,16'h0,16'h18,16'h18,16'h10,16'h0000}, 1,8'd10,16'h0000,1,4'd0}, // R7
    '{16'h0088,1,1,0,16'h0,16'h0,0,0,{16'h0,16'h0,16'h4018,16'h2018,16'h10,16'h8}, 1,8'd11,16'h2018,1,4'd3}, // R9 R10
    '{16'h0090,1,1,0,16'h0,16'h0,0,0,{16'h4020,16'h0,16'h18,16'h18,16'h10,16'h8}, 1,8'd10,16'h4020,1,4'd5}, // R9
    '{16'h0098,1,1,0,16'h0,16'h0,0,0,{16'h0,16'h0,16'h18,16'h6018,16'h10,16'h8}, 1,8'd10,16'h6018,1,4'd3}, // R9
    '{16'h00A0,1,1,1,16'h10,16'h20,1,0,SB, 0,8'd0,16'h0000,0,4'd6}  // R3 R4
  };

  logic [15:0] req_log [8];
  int          nreq = 0, done_cnt = 0;
  bit          mon_en = 0;
  logic [95:0] cur_segs;
  logic [15:0] cur_tss;
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (mon_en && desc_req && desc_rsp_valid) begin
      if (nreq < 8) req_log[nreq] = desc_sel;
      nreq++;
      chk(seg_q == cur_segs, "R5 loaded before request", seg_q, cur_segs);
      chk(tr_q == cur_tss, "R4 committed before request", 96'(tr_q), 96'(cur_tss));
    end
  end

  task automatic run_vec(input vec_t v, input int n);
    logic [15:0] p_tr, p_link, s;
    logic [95:0] p_seg;
    logic [15:0] exp_list [6];
    int w, k;
    @(negedge clk);
    p_tr = tr_q; p_link = link_q; p_seg = seg_q;
    tss_sel = v.tss; tss_type_ok = v.tok; tss_present = v.pres; stk_fetch = v.stk;
    stk_ofs = v.ofs; tss_limit = v.lim; from_call = v.call; ext_evt = v.ext; seg_sel_in = v.segs;
    lat = n[0]; cur_segs = v.segs; cur_tss = v.tss; nreq = 0; mon_en = 1; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R1 busy after start", 96'(busy), 96'd1);
    w = 0;
    while (!done && w < 100) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R1 done pulse", 96'(done), 96'd1);
    chk(fault_valid == v.e_flt, "R10 fault flag", 96'(fault_valid), 96'(v.e_flt));
    if (v.e_flt) begin
      chk(fault_vec == v.e_vec, "R7 R8 R9 vector", 96'(fault_vec), 96'(v.e_vec));
      chk(fault_err == v.e_err, "R11 error code", 96'(fault_err), 96'(v.e_err));
      chk(fault_ctx == v.e_ctx, "R10 context", 96'(fault_ctx), 96'(v.e_ctx));
    end
    if (v.e_flt && !v.e_ctx) begin
      chk(tr_q == p_tr, "R2 task register kept", 96'(tr_q), 96'(p_tr));
      chk(link_q == p_link, "R2 link kept", 96'(link_q), 96'(p_link));
      chk(seg_q == p_seg, "R2 segments kept", seg_q, p_seg);
    end else begin
      chk(tr_q == v.tss, "R4 task register", 96'(tr_q), 96'(v.tss));
      chk(link_q == (v.call ? p_tr : p_link), "R4 back-link", 96'(link_q), 96'(v.call ? p_tr : p_link));
      chk(seg_q == v.segs, "R5 all segments loaded", seg_q, v.segs);
    end
    chk(nreq == int'(v.e_nreq), "R6 request count", 96'(nreq), 96'(v.e_nreq));
    k = 0;
    for (int i = 0; i < 6; i++) begin
      s = v.segs[16*i +: 16];
      if (s[15:2] != 0) begin exp_list[k] = s; k++; end
    end
    for (int j = 0; j < 6; j++)
      if (j < nreq && j < int'(v.e_nreq))
        chk(req_log[j] == exp_list[j], "R6 request order", 96'(req_log[j]), 96'(exp_list[j]));
    mon_en = 0;
    @(negedge clk);
    chk(!done && !busy, "R1 single-cycle done", 96'({done, busy}), 96'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int dc;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault_valid && !desc_req, "R12 reset outputs", 96'({busy, done, fault_valid, desc_req}), 96'd0);
    chk(tr_q == 0 && link_q == 0 && seg_q == 0, "R12 reset registers", seg_q, 96'd0);
    rst_n = 1;
    for (int n = 0; n < NV; n++) run_vec(VECS[n], n);

    // R1: second start while busy is ignored
    @(negedge clk);
    lat = 0; dc = done_cnt;
    tss_sel = 16'h00B0; tss_type_ok = 1; tss_present = 1; stk_fetch = 0; from_call = 0; ext_evt = 0;
    seg_sel_in = SA; start = 1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    start = 0;
    @(negedge clk); @(negedge clk);
    tss_sel = 16'h00B8; start = 1;
    @(negedge clk);
    start = 0;
    repeat (30) @(negedge clk);
    chk(done_cnt - dc == 1, "R1 one completion", 96'(done_cnt - dc), 96'd1);
    chk(tr_q == 16'h00B0, "R1 busy start ignored", 96'(tr_q), 96'h00B0);

    // R12: reset during the check phase abandons the switch
    @(negedge clk);
    dc = done_cnt;
    tss_sel = 16'h00C0; seg_sel_in = SB; start = 1;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    chk(tr_q == 16'h00C0 && busy, "R12 switch under way", 96'(tr_q), 96'h00C0);
    rst_n = 0;
    @(negedge clk);
    chk(tr_q == 0 && link_q == 0 && seg_q == 0, "R12 registers cleared", seg_q, 96'd0);
    chk(!busy && !desc_req, "R12 idle after reset", 96'({busy, desc_req}), 96'd0);
    rst_n = 1;
    repeat (15) @(negedge clk);
    chk(done_cnt == dc, "R12 no done after abandon", 96'(done_cnt), 96'(dc));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule